// File: doc/BRIEF.md
# Clock Output Power Management Controller

This block is the control logic of a multi-source clock generator. It decides whether each configurable clock output runs, is held quietly low, or is three-stated, and whether each PLL and the reference oscillator is powered. It takes two asynchronous pins as inputs: an active-low output-enable/shutdown pin and a select/suspend pin. A set of static configuration bits tells it how to read those pins. The analog PLLs, the oscillators and the pad drivers sit outside the block. They appear here only as lock flags coming in and power-down and enable controls going out. The always-on low-frequency output is not handled here.

The shutdown pin has two meanings, chosen by a configuration flag. With the flag clear, the pin only three-states the outputs. With the flag set, it also powers down every frequency source. The select/suspend pin acts as a plain select bit unless suspend is enabled. When suspend is enabled, a low level powers down a masked set of PLLs and three-states a masked set of outputs. Any output fed by a suspended PLL is added to the suspended set automatically.

After a source is powered up again, a per-source timer must expire and the source's lock flag must be high before the outputs it feeds start running. Every output's state changes only while that output's clock is low, so no shortened pulse reaches the pad.

Top module: `clkpm_ctrl`

## Requirements
- R1: While the synchronised shutdown pin is low, every configurable output is three-stated. Output state encoding: running = enable 1 / three-state 0, quiet = 0/0, three-stated = 0/1.
- R2: With the shutdown-mode flag set, a low shutdown pin also raises every PLL power-down and the reference-oscillator power-down. With the flag clear, these stay low.
- R3: With suspend enabled and the select/suspend pin low, every PLL whose bit is set in the PLL suspend mask is powered down, and every output whose bit is set in the output suspend mask is three-stated.
- R4: During suspend, an output whose source is a suspended PLL is three-stated even when its own mask bit is clear.
- R5: With suspend not enabled, the select/suspend pin has no effect on outputs or power-downs, and `sel2_sel` follows the synchronised pin. With suspend enabled, `sel2_sel` is 0.
- R6: Suspending an output only three-states it. Its source PLL stays powered unless that PLL is in the PLL suspend mask.
- R7: Each output selects its source by a field of width SRC_W in `cfg_out_src` (output o at bits o*SRC_W upward). Sources 0 to N_PLL-1 are PLLs, with 0 being the CPU PLL, and source N_PLL is the reference oscillator. After a source powers up, its outputs stay quiet until its timer has counted CPU_WAIT_CYC cycles (source 0), PLL_WAIT_CYC cycles (other PLLs) or REF_WAIT_CYC cycles (reference).
- R8: An output that is neither shut down nor suspended, and whose source lock flag is low, is quiet, not three-stated.
- R9: An output's enable and three-state controls change only at clock edges where its `out_clk_lvl` bit is low.
- R10: Reset leaves every output quiet and every power-down low. The timers then run, so the outputs start running once their waits complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_shdn_n | input | 1 | Asynchronous output-enable / shutdown pin, active low |
| sel2_susp_n | input | 1 | Asynchronous select bit / suspend pin, suspend active low |
| cfg_shdn_mode | input | 1 | 1: a low shutdown pin also powers down all sources |
| cfg_susp_en | input | 1 | 1: the select/suspend pin acts as suspend |
| cfg_out_susp_mask | input | N_OUT | Outputs three-stated during suspend |
| cfg_pll_susp_mask | input | N_PLL | PLLs powered down during suspend |
| cfg_out_src | input | N_OUT*SRC_W | Source index per output |
| src_lock | input | N_PLL+1 | Lock/stable flag per source |
| out_clk_lvl | input | N_OUT | Current level of each output clock |
| out_en | output | N_OUT | Output clock running |
| out_hiz | output | N_OUT | Output three-stated |
| pll_pd | output | N_PLL | PLL power-down |
| ref_osc_pd | output | 1 | Reference oscillator power-down |
| sel2_sel | output | 1 | Synchronised select bit 2 |

## Verification
Assertions check the following on every cycle:
- An output never changes state while its clock is high.
- A pending three-state request takes effect at the first low-clock edge.
- An output starts running only after a cycle in which its source was ready.
- A timer is cleared while its source is powered down and never counts past its limit.
- The oscillator is powered down only together with all PLLs.

Only the bench scenarios can show the full picture: the actual lengths of the per-source lock waits, the forced suspension of outputs that follow a suspended PLL, the different meanings of the shutdown pin, and the select-bit pass-through. The bench checks these against expected states computed from the pin and configuration settings.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    typedef enum logic [1:0] {
        OM_QUIET = 2'd0,
        OM_RUN   = 2'd1,
        OM_HIZ   = 2'd2
    } out_mode_e;

    typedef struct packed {
        logic shdn;      // shutdown pin active
        logic susp;      // suspend active
        logic full_off;  // shutdown that also powers down sources
    } pin_state_t;

    // Lock-wait length for a source index: 0 is the CPU PLL, n_pll is the reference.
    function automatic int unsigned wait_for_src(input int unsigned s,
                                                 input int unsigned n_pll,
                                                 input int unsigned cpu_w,
                                                 input int unsigned pll_w,
                                                 input int unsigned ref_w);
        if (s == 0)          return cpu_w;
        else if (s == n_pll) return ref_w;
        else                 return pll_w;
    endfunction

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/clkpm_lock_timer.sv
module clkpm_lock_timer #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic lock,
    output logic ready
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || pd)          cnt_q <= '0;
        else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
    end

    assign ready = lock && !pd && (cnt_q == LIM);

    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(pd) |-> (cnt_q == '0));  // R7
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);  // R7
endmodule

// File: rtl/clkpm_out_ctrl.sv
module clkpm_out_ctrl
    import clkpm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_lvl,
    input  logic hiz_req,
    input  logic src_ok,
    output logic en,
    output logic hiz
);
    out_mode_e mode_q, mode_d;

    always_comb begin
        if (hiz_req)     mode_d = OM_HIZ;
        else if (src_ok) mode_d = OM_RUN;
        else             mode_d = OM_QUIET;
    end

    // State moves only while the output clock is low.
    always_ff @(posedge clk) begin
        if (rst)           mode_q <= OM_QUIET;
        else if (!clk_lvl) mode_q <= mode_d;
    end

    assign en  = (mode_q == OM_RUN);
    assign hiz = (mode_q == OM_HIZ);

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> !$past(clk_lvl));  // R9
    AST_HIZ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!clk_lvl && hiz_req) |=> (mode_q == OM_HIZ));  // R1
    AST_RUN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OM_RUN && $past(mode_q) != OM_RUN) |-> $past(src_ok));  // R7
endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int unsigned N_OUT        = 7,
    parameter int unsigned N_PLL        = 3,
    parameter int unsigned CPU_WAIT_CYC = 50000,
    parameter int unsigned PLL_WAIT_CYC = 1000,
    parameter int unsigned REF_WAIT_CYC = 100,
    localparam int unsigned N_SRC       = N_PLL + 1,
    localparam int unsigned SRC_W       = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   oe_shdn_n,
    input  logic                   sel2_susp_n,
    input  logic                   cfg_shdn_mode,
    input  logic                   cfg_susp_en,
    input  logic [N_OUT-1:0]       cfg_out_susp_mask,
    input  logic [N_PLL-1:0]       cfg_pll_susp_mask,
    input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
    input  logic [N_SRC-1:0]       src_lock,
    input  logic [N_OUT-1:0]       out_clk_lvl,
    output logic [N_OUT-1:0]       out_en,
    output logic [N_OUT-1:0]       out_hiz,
    output logic [N_PLL-1:0]       pll_pd,
    output logic                   ref_osc_pd,
    output logic                   sel2_sel
);
    localparam int unsigned SRC_SPAN = 2 ** SRC_W;

    logic [1:0]          pins_q;
    pin_state_t          ps;
    logic [N_SRC-1:0]    src_pd;
    logic [N_SRC-1:0]    src_ready;
    logic [SRC_SPAN-1:0] ready_ext;
    logic [SRC_SPAN-1:0] pmask_ext;

    clkpm_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({oe_shdn_n, sel2_susp_n}),
        .q   (pins_q)
    );

    always_comb begin
        ps.shdn     = !pins_q[1];
        ps.susp     = cfg_susp_en && !pins_q[0];
        ps.full_off = ps.shdn && cfg_shdn_mode;
    end

    generate
        for (genvar p = 0; p < N_PLL; p++) begin : g_pll_pd
            assign src_pd[p] = ps.full_off || (ps.susp && cfg_pll_susp_mask[p]);
        end
    endgenerate
    assign src_pd[N_PLL] = ps.full_off;

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_timer
            localparam int unsigned LIM =
                wait_for_src(s, N_PLL, CPU_WAIT_CYC, PLL_WAIT_CYC, REF_WAIT_CYC);
            clkpm_lock_timer #(.LIMIT(LIM)) u_timer (
                .clk   (clk),
                .rst   (rst),
                .pd    (src_pd[s]),
                .lock  (src_lock[s]),
                .ready (src_ready[s])
            );
        end
    endgenerate

    // Zero-extended so that any index value selects a defined bit; the
    // reference index lands on a zero PLL-mask bit.
    assign ready_ext = SRC_SPAN'(src_ready);
    assign pmask_ext = SRC_SPAN'(cfg_pll_susp_mask);

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            logic [SRC_W-1:0] src_idx;
            logic             hiz_req;
            assign src_idx = cfg_out_src[o*SRC_W +: SRC_W];
            assign hiz_req = ps.shdn ||
                             (ps.susp && (cfg_out_susp_mask[o] || pmask_ext[src_idx]));
            clkpm_out_ctrl u_out (
                .clk     (clk),
                .rst     (rst),
                .clk_lvl (out_clk_lvl[o]),
                .hiz_req (hiz_req),
                .src_ok  (ready_ext[src_idx]),
                .en      (out_en[o]),
                .hiz     (out_hiz[o])
            );
        end
    endgenerate

    assign pll_pd     = src_pd[N_PLL-1:0];
    assign ref_osc_pd = src_pd[N_PLL];
    assign sel2_sel   = cfg_susp_en ? 1'b0 : pins_q[0];

    AST_REF_PD_PLL: assert property (@(posedge clk) disable iff (rst)
        ref_osc_pd |-> (&pll_pd));  // R2
    AST_SUSP_PD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cfg_susp_en && oe_shdn_n && $past(oe_shdn_n) && $past(oe_shdn_n, 2))
        |-> (pll_pd == '0));  // R5
endmodule

// File: tb/tb_clkpm_ctrl.sv
module tb_clkpm_ctrl;
    localparam int N_OUT = 7;
    localparam int N_PLL = 3;
    localparam int N_SRC = N_PLL + 1;
    localparam int SRC_W = $clog2(N_SRC);
    localparam int CPU_W = 40;
    localparam int PLL_W = 10;
    localparam int REF_W = 6;
    localparam int SETTLE = CPU_W + 12;

    logic clk = 0;
    logic rst = 1;
    logic oe_shdn_n = 1, sel2_susp_n = 1;
    logic cfg_shdn_mode = 0, cfg_susp_en = 0;
    logic [N_OUT-1:0] cfg_out_susp_mask = '0;
    logic [N_PLL-1:0] cfg_pll_susp_mask = '0;
    logic [N_OUT*SRC_W-1:0] cfg_out_src;
    logic [N_SRC-1:0] src_lock = '1;
    logic [N_OUT-1:0] out_clk_lvl = '0;
    logic [N_OUT-1:0] hold_hi = '0;
    logic [N_OUT-1:0] out_en, out_hiz;
    logic [N_PLL-1:0] pll_pd;
    logic ref_osc_pd, sel2_sel;

    int n_chk = 0, n_bad = 0, runt_cnt = 0;
    logic [N_OUT-1:0] en_p = '0, hiz_p = '0, lvl_p = '0;

    clkpm_ctrl #(.N_OUT(N_OUT), .N_PLL(N_PLL), .CPU_WAIT_CYC(CPU_W),
                 .PLL_WAIT_CYC(PLL_W), .REF_WAIT_CYC(REF_W)) dut (
        .clk(clk), .rst(rst), .oe_shdn_n(oe_shdn_n), .sel2_susp_n(sel2_susp_n),
        .cfg_shdn_mode(cfg_shdn_mode), .cfg_susp_en(cfg_susp_en),
        .cfg_out_susp_mask(cfg_out_susp_mask), .cfg_pll_susp_mask(cfg_pll_susp_mask),
        .cfg_out_src(cfg_out_src), .src_lock(src_lock), .out_clk_lvl(out_clk_lvl),
        .out_en(out_en), .out_hiz(out_hiz), .pll_pd(pll_pd),
        .ref_osc_pd(ref_osc_pd), .sel2_sel(sel2_sel)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Output clock levels toggle away from the control edge.
    always @(posedge clk) begin
        #2;
        out_clk_lvl <= hold_hi | ~out_clk_lvl;
    end

    // R9 monitor: a state change across an edge where the clock level was high.
    always @(negedge clk) begin
        if (!rst) begin
            if (|(((en_p ^ out_en) | (hiz_p ^ out_hiz)) & lvl_p)) runt_cnt++;
        end
        en_p  <= out_en;
        hiz_p <= out_hiz;
        lvl_p <= out_clk_lvl;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int src_of(input int o);
        return int'(cfg_out_src[o*SRC_W +: SRC_W]);
    endfunction

    function automatic logic [1:0] exp_mode(input int o);
        logic sh, su, full, spd, hz;
        int s;
        s    = src_of(o);
        sh   = !oe_shdn_n;
        su   = cfg_susp_en && !sel2_susp_n;
        full = sh && cfg_shdn_mode;
        spd  = (s < N_PLL) ? (full || (su && cfg_pll_susp_mask[s])) : full;
        hz   = sh || (su && (cfg_out_susp_mask[o] || (s < N_PLL && cfg_pll_susp_mask[s])));
        if (hz) return 2'b10;
        if (src_lock[s] && !spd) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [N_PLL-1:0] exp_pll_pd();
        logic full;
        full = !oe_shdn_n && cfg_shdn_mode;
        return {N_PLL{full}} | ({N_PLL{cfg_susp_en && !sel2_susp_n}} & cfg_pll_susp_mask);
    endfunction

    task automatic check_all(input string req);
        for (int o = 0; o < N_OUT; o++)
            chk(req, 32'({out_hiz[o], out_en[o]}), 32'(exp_mode(o)));
        chk(req, 32'(pll_pd), 32'(exp_pll_pd()));
        chk(req, 32'(ref_osc_pd), 32'(!oe_shdn_n && cfg_shdn_mode));
        chk(req, 32'(sel2_sel), 32'(cfg_susp_en ? 1'b0 : sel2_susp_n));
    endtask

    task automatic set_src(input int o, input int s);
        cfg_out_src[o*SRC_W +: SRC_W] = SRC_W'(s);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h2291_5eed));
        for (int o = 0; o < N_OUT; o++) set_src(o, o % N_SRC);
        wait_cyc(4);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        chk("R10 quiet en", 32'(out_en), 0);
        chk("R10 quiet hiz", 32'(out_hiz), 0);
        chk("R10 pd", 32'({ref_osc_pd, pll_pd}), 0);
        wait_cyc(SETTLE);
        chk("R10 running after wait", 32'(out_en), 32'({N_OUT{1'b1}}));
        check_all("R10");

        // R1 / R2: output-enable meaning only
        oe_shdn_n = 0; cfg_shdn_mode = 0;
        wait_cyc(6);
        chk("R1 all hiz", 32'(out_hiz), 32'({N_OUT{1'b1}}));
        chk("R2 flag clear no pd", 32'({ref_osc_pd, pll_pd}), 0);
        check_all("R1");
        cfg_shdn_mode = 1;
        wait_cyc(4);
        chk("R2 flag set all pd", 32'({ref_osc_pd, pll_pd}), 32'({(N_PLL+1){1'b1}}));

        // R7: lock-wait per source after leaving full shutdown
        set_src(0, 0); set_src(1, 1); set_src(2, N_PLL);
        wait_cyc(4);
        oe_shdn_n = 1;
        wait_cyc(8);
        chk("R7 pll quiet early", 32'({out_hiz[1], out_en[1]}), 32'(2'b00));
        chk("R7 cpu quiet early", 32'({out_hiz[0], out_en[0]}), 32'(2'b00));
        wait_cyc(8);
        chk("R7 pll run", 32'({out_hiz[1], out_en[1]}), 32'(2'b01));
        chk("R7 ref run", 32'({out_hiz[2], out_en[2]}), 32'(2'b01));
        wait_cyc(14);
        chk("R7 cpu still quiet", 32'({out_hiz[0], out_en[0]}), 32'(2'b00));
        wait_cyc(20);
        chk("R7 cpu run", 32'({out_hiz[0], out_en[0]}), 32'(2'b01));

        // R8: lock low gives quiet, not hiz
        src_lock[1] = 0;
        wait_cyc(4);
        chk("R8 unlocked quiet", 32'({out_hiz[1], out_en[1]}), 32'(2'b00));
        src_lock[1] = 1;
        wait_cyc(4);
        chk("R8 relocked run", 32'({out_hiz[1], out_en[1]}), 32'(2'b01));

        // R3 / R4 / R6: suspend with forced outputs
        cfg_shdn_mode = 0;
        set_src(3, 2); set_src(1, 1); set_src(5, 1);
        cfg_susp_en = 1; cfg_pll_susp_mask = 3'b010; cfg_out_susp_mask = 7'b000_1000;
        sel2_susp_n = 0;
        wait_cyc(6);
        chk("R3 pll1 pd", 32'(pll_pd), 32'(3'b010));
        chk("R4 forced out1 hiz", 32'({out_hiz[1], out_en[1]}), 32'(2'b10));
        chk("R4 forced out5 hiz", 32'({out_hiz[5], out_en[5]}), 32'(2'b10));
        chk("R6 out3 hiz", 32'({out_hiz[3], out_en[3]}), 32'(2'b10));
        chk("R6 pll2 still on", 32'(pll_pd[2]), 0);
        check_all("R3");
        sel2_susp_n = 1;
        wait_cyc(SETTLE);
        check_all("R3 resume");

        // R5: select bit meaning
        cfg_susp_en = 0;
        sel2_susp_n = 0;
        wait_cyc(4);
        chk("R5 sel follows", 32'(sel2_sel), 0);
        chk("R5 no pd", 32'(pll_pd), 0);
        chk("R5 outputs run", 32'(out_en), 32'({N_OUT{1'b1}}));
        sel2_susp_n = 1;
        wait_cyc(4);
        chk("R5 sel follows high", 32'(sel2_sel), 1);
        cfg_susp_en = 1;
        wait_cyc(1);
        chk("R5 sel masked", 32'(sel2_sel), 0);
        cfg_susp_en = 0;

        // R9: clock held high blocks the change
        hold_hi[3] = 1;
        wait_cyc(2);
        oe_shdn_n = 0;
        wait_cyc(8);
        chk("R9 held output unchanged", 32'({out_hiz[3], out_en[3]}), 32'(2'b01));
        chk("R1 other output hiz", 32'({out_hiz[4], out_en[4]}), 32'(2'b10));
        hold_hi[3] = 0;
        wait_cyc(4);
        chk("R9 released output hiz", 32'({out_hiz[3], out_en[3]}), 32'(2'b10));
        oe_shdn_n = 1;
        wait_cyc(SETTLE);

        // Random vectors covering R1 R2 R3 R4 R5 R6 R8
        for (int v = 0; v < 50; v++) begin
            oe_shdn_n         = ($urandom_range(3) != 0);
            sel2_susp_n       = $urandom_range(1);
            cfg_shdn_mode     = $urandom_range(1);
            cfg_susp_en       = $urandom_range(1);
            cfg_out_susp_mask = N_OUT'($urandom);
            cfg_pll_susp_mask = N_PLL'($urandom);
            for (int o = 0; o < N_OUT; o++) set_src(o, $urandom_range(N_SRC - 1));
            for (int s = 0; s < N_SRC; s++) src_lock[s] = ($urandom_range(3) != 0);
            wait_cyc(SETTLE);
            check_all("R1 R2 R3 R4 R5 R6 R8 random");
        end

        chk("R9 no change while clock high", 32'(runt_cnt), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule